// File: doc/BRIEF.md
# CRC-16 Folding Accumulator (T10 DIF polynomial)

This block computes the running CRC state of a message that arrives sixteen bytes per clock. Instead of shifting the message through a bit-serial or byte-serial register, it keeps a 128-bit polynomial remainder. On each new beat it multiplies the two 64-bit halves of that remainder by two precomputed constants, x^192 mod G and x^128 mod G, and XORs the sum into the next block. G is the CRC-16 generator 0x18BB7 (x^16+x^15+x^11+x^9+x^8+x^7+x^5+x^4+x^2+x+1). The result is a 128-bit residue M(x) with the property that (x^16 · M(x)) mod G equals the CRC of the message. A separate downstream stage turns M(x) into the 16-bit checksum.

A message starts with a one-cycle start pulse that carries the initial CRC value. Full 16-byte beats follow, and the beat flagged as last carries a byte count. If the last beat is short (1 to 15 bytes), the engine splits the remainder again. The top bytes of the state are folded into a new 16-byte chunk made of the shifted state and the trailing bytes. This costs one extra cycle before the residue is presented. Every message is at least 16 bytes long, so the first beat is always full.

Top module: `crc16_fold_acc`

## Requirements
- R1: Byte k of a beat (beat_data_i[8k+7:8k]) is the k-th message byte of that beat. Byte 0 becomes the most significant coefficient of the 128-bit block, so the block is the beat with its byte order reversed.
- R2: The initial CRC is XORed into bits [127:112] of the first block. For a message of exactly 16 bytes, the residue equals that block with no folding.
- R3: On a presented residue M, (x^16 · M) mod 0x18BB7 equals the non-reflected CRC of the message, taken MSB first, started from the initial CRC, with no final XOR. This holds for every length from 16 to 300 bytes.
- R4: A last beat with count 16 gives a one-cycle residue_valid_o pulse in the cycle after the beat is accepted.
- R5: A last beat with count 1 to 15 uses only its lowest count bytes; the other bytes of that beat have no effect on the residue. residue_valid_o rises two cycles after that beat, not one. beat_count_i is only read with the last flag and holds 1..16.
- R6: After reset, and after a message ends, beats are ignored until start_i. A start pulse discards any partial message, and no residue_valid_o is raised without a last beat. After reset, residue_o is zero and residue_valid_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Begins a new message; a beat in the same cycle is ignored |
| init_crc_i | input | 16 | Initial CRC, captured with start_i |
| beat_valid_i | input | 1 | A data beat is present |
| beat_data_i | input | 128 | Sixteen message bytes, byte 0 in bits [7:0] |
| beat_last_i | input | 1 | This beat ends the message |
| beat_count_i | input | 5 | Valid bytes in the last beat (1..16) |
| residue_o | output | 128 | Folded remainder M(x) |
| residue_valid_o | output | 1 | One-cycle pulse: residue_o is final |

## Verification
The assertions rely on the following input contract:
- Whenever a last beat is offered, its byte count lies between 1 and 16.
- The first beat after start_i is full.
- start_i is never combined with a beat it is meant to carry.

The stimulus respects this contract. Each message is preceded by its own start cycle and followed by idle cycles. Counts are derived from lengths of 16 or more, and bytes beyond the count are filled with a fixed pattern. Beats that break the protocol are offered only while the engine is idle: before the first start, after a last beat, or as an abandoned prefix that the next start clears.

// File: rtl/crc16_fold_pkg.sv
// Package: shared types and constant math for the CRC-16 folding accumulator.
// Assumes a 16-bit CRC; the generator is given with its implicit x^16 term.
package crc16_fold_pkg;

    localparam int unsigned CRC_W = 16;
    localparam logic [CRC_W:0] GEN_POLY = 17'h18BB7;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FIRST = 2'd1,
        ST_RUN   = 2'd2,
        ST_PART  = 2'd3
    } fold_state_e;

    // Computes x^n mod G by repeated multiply-by-x, for elaboration-time constants.
    function automatic logic [CRC_W-1:0] xpow_mod(input int unsigned n, input logic [CRC_W:0] g);
        logic [CRC_W:0] r;
        r = {{CRC_W{1'b0}}, 1'b1};
        for (int unsigned i = 0; i < n; i++) begin
            r = r << 1;
            if (r[CRC_W]) r = r ^ g;
        end
        return r[CRC_W-1:0];
    endfunction

endpackage

// File: rtl/crc_beat_order.sv
// Reorders a beat so that its first byte becomes the most significant
// polynomial coefficient byte. Pure wiring; assumes byte 0 sits in bits [7:0].
module crc_beat_order #(
    parameter int unsigned BYTES = 16
) (
    input  logic [BYTES*8-1:0] data_i,
    output logic [BYTES*8-1:0] poly_o
);
    for (genvar g = 0; g < BYTES; g++) begin : g_byte
        // Byte g of the beat lands at coefficient byte BYTES-1-g.
        assign poly_o[8*(BYTES-1-g) +: 8] = data_i[8*g +: 8];
    end
endmodule

// File: rtl/crc_fold_mul.sv
// Folds a STATE_W-bit remainder forward by STATE_W bits: the low half is
// carry-less multiplied by K_LO, the high half by K_HI, products summed.
// Assumes STATE_W/2 + KW <= STATE_W so that no product bit is lost.
module crc_fold_mul #(
    parameter int unsigned STATE_W = 128,
    parameter int unsigned KW      = 16,
    parameter logic [KW-1:0] K_LO  = '0,
    parameter logic [KW-1:0] K_HI  = '0
) (
    input  logic [STATE_W-1:0] state_i,
    output logic [STATE_W-1:0] fold_o
);
    localparam int unsigned HALF_W = STATE_W / 2;

    logic [HALF_W-1:0] lo, hi;
    assign lo = state_i[HALF_W-1:0];
    assign hi = state_i[STATE_W-1:HALF_W];

    // Shift-and-XOR multiply of both halves by their fixed constants.
    always_comb begin
        fold_o = '0;
        for (int i = 0; i < int'(KW); i++) begin
            if (K_LO[i]) fold_o = fold_o ^ (STATE_W'(lo) << i);
            if (K_HI[i]) fold_o = fold_o ^ (STATE_W'(hi) << i);
        end
    end
endmodule

// File: rtl/crc_tail_split.sv
// Re-splits the remainder for a short final beat of len bytes (1..15):
// lead_o holds the top len bytes of the state, chunk_o holds the state moved
// up by len bytes with the len trailing message bytes filled in below.
// Assumes blk_i carries the trailing bytes in its top len coefficient bytes.
module crc_tail_split #(
    parameter int unsigned STATE_W = 128,
    parameter int unsigned CNT_W   = 5
) (
    input  logic [STATE_W-1:0] state_i,
    input  logic [STATE_W-1:0] blk_i,
    input  logic [CNT_W-1:0]   len_i,
    output logic [STATE_W-1:0] lead_o,
    output logic [STATE_W-1:0] chunk_o
);
    localparam int unsigned SH_W = CNT_W + 3;

    logic [SH_W-1:0] sh, rsh;

    // Byte counts become bit shift amounts for both halves of the split.
    always_comb begin
        sh      = {len_i, 3'b000};
        rsh     = SH_W'(STATE_W) - sh;
        lead_o  = state_i >> rsh;
        chunk_o = (state_i << sh) | (blk_i >> rsh);
    end
endmodule

// File: rtl/crc16_fold_acc.sv
// Streaming CRC-16 folding accumulator. Takes one 16-byte beat per cycle,
// keeps a 128-bit remainder and presents it as residue_o with a one-cycle
// residue_valid_o. Assumes messages of at least one full beat, a last-beat
// count of 1..16, and a start pulse before each message.
module crc16_fold_acc
    import crc16_fold_pkg::*;
#(
    parameter int unsigned BEAT_BYTES = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start_i,
    input  logic [15:0]             init_crc_i,
    input  logic                    beat_valid_i,
    input  logic [BEAT_BYTES*8-1:0] beat_data_i,
    input  logic                    beat_last_i,
    input  logic [$clog2(BEAT_BYTES+1)-1:0] beat_count_i,
    output logic [BEAT_BYTES*8-1:0] residue_o,
    output logic                    residue_valid_o
);
    localparam int unsigned BEAT_W = BEAT_BYTES * 8;
    localparam int unsigned CNT_W  = $clog2(BEAT_BYTES + 1);
    localparam logic [CRC_W-1:0] K_LO = xpow_mod(BEAT_W, GEN_POLY);
    localparam logic [CRC_W-1:0] K_HI = xpow_mod(BEAT_W + BEAT_W / 2, GEN_POLY);

    fold_state_e         fsm_q;
    logic [BEAT_W-1:0]   acc_q, tail_q;
    logic [CNT_W-1:0]    tlen_q;
    logic [CRC_W-1:0]    init_q;
    logic                valid_q;

    logic [BEAT_W-1:0]   blk, fold_in, fold_out, lead, chunk, init_word;
    logic                is_short, take_beat;

    crc_beat_order #(.BYTES(BEAT_BYTES)) u_order (
        .data_i (beat_data_i),
        .poly_o (blk)
    );

    crc_tail_split #(.STATE_W(BEAT_W), .CNT_W(CNT_W)) u_split (
        .state_i (acc_q),
        .blk_i   (tail_q),
        .len_i   (tlen_q),
        .lead_o  (lead),
        .chunk_o (chunk)
    );

    crc_fold_mul #(.STATE_W(BEAT_W), .KW(CRC_W), .K_LO(K_LO), .K_HI(K_HI)) u_fold (
        .state_i (fold_in),
        .fold_o  (fold_out)
    );

    // Decode of the incoming beat: short tail, acceptance, seed word, fold source.
    always_comb begin
        is_short  = (beat_count_i != '0) && (beat_count_i < CNT_W'(BEAT_BYTES));
        take_beat = beat_valid_i && !start_i && (fsm_q == ST_FIRST || fsm_q == ST_RUN);
        init_word = {init_q, {(BEAT_W-CRC_W){1'b0}}};
        fold_in   = (fsm_q == ST_PART) ? lead : acc_q;
    end

    // Message sequencing: arm on start, run beats, insert the tail-split cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fsm_q <= ST_IDLE;
        end else if (start_i) begin
            fsm_q <= ST_FIRST;
        end else begin
            case (fsm_q)
                ST_FIRST: if (beat_valid_i) fsm_q <= beat_last_i ? ST_IDLE : ST_RUN;
                ST_RUN:   if (beat_valid_i && beat_last_i) fsm_q <= is_short ? ST_PART : ST_IDLE;
                ST_PART:  fsm_q <= ST_IDLE;
                default:  fsm_q <= ST_IDLE;
            endcase
        end
    end

    // Remainder update: seed, fold per beat, or complete the short-tail split.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= '0;
        end else if (fsm_q == ST_PART) begin
            acc_q <= fold_out ^ chunk;
        end else if (start_i) begin
            acc_q <= '0;
        end else if (take_beat && fsm_q == ST_FIRST) begin
            acc_q <= blk ^ init_word;
        end else if (take_beat && !(beat_last_i && is_short)) begin
            acc_q <= fold_out ^ blk;
        end
    end

    // Captures the initial CRC and the short final beat for the split cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            init_q <= '0;
            tail_q <= '0;
            tlen_q <= '0;
        end else begin
            if (start_i) init_q <= init_crc_i;
            if (take_beat && fsm_q == ST_RUN && beat_last_i && is_short) begin
                tail_q <= blk;
                tlen_q <= beat_count_i;
            end
        end
    end

    // Completion pulse: one cycle after a full last beat or after the split cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
        end else begin
            valid_q <= (fsm_q == ST_PART)
                    || (take_beat && beat_last_i && (fsm_q == ST_FIRST || !is_short));
        end
    end

    assign residue_o       = acc_q;
    assign residue_valid_o = valid_q;

endmodule

// File: rtl/crc16_fold_acc_chk.sv
// Protocol and timing checker for crc16_fold_acc, attached by bind.
// Assumes the sequencing state is visible as fsm_i.
module crc16_fold_acc_chk
    import crc16_fold_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        start_i,
    input logic        beat_valid_i,
    input logic        beat_last_i,
    input logic [4:0]  beat_count_i,
    input logic        residue_valid_o,
    input fold_state_e fsm_i
);
    logic running, short_last;
    assign running    = (fsm_i == ST_FIRST) || (fsm_i == ST_RUN);
    assign short_last = beat_count_i != 5'd16;

    AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        residue_valid_o |=> !residue_valid_o); // R4
    AST_FULL_LAST_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (running && !start_i && beat_valid_i && beat_last_i
         && (fsm_i == ST_FIRST || !short_last)) |=> residue_valid_o); // R4
    AST_SHORT_DEFERS: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_i == ST_RUN && !start_i && beat_valid_i && beat_last_i && short_last)
        |=> (!residue_valid_o && fsm_i == ST_PART)); // R5
    AST_SPLIT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_i == ST_PART) |=> residue_valid_o); // R5
    AST_LAST_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        (running && beat_valid_i && beat_last_i)
        |-> (beat_count_i >= 5'd1 && beat_count_i <= 5'd16)); // R5
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_i == ST_IDLE) |=> !residue_valid_o); // R6
    AST_START_ARMS: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (fsm_i == ST_FIRST)); // R6
endmodule

bind crc16_fold_acc crc16_fold_acc_chk u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .start_i         (start_i),
    .beat_valid_i    (beat_valid_i),
    .beat_last_i     (beat_last_i),
    .beat_count_i    (beat_count_i),
    .residue_valid_o (residue_valid_o),
    .fsm_i           (fsm_q)
);

// File: tb/crc16_fold_acc_tb.sv
// Bench: behavioural bit-serial CRC model, every-clock comparison of the
// completion pulse, and CRC reduction of every presented residue.
module crc16_fold_acc_tb;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic [15:0]  init_crc = '0;
    logic         beat_valid = 1'b0;
    logic [127:0] beat_data = '0;
    logic         beat_last = 1'b0;
    logic [4:0]   beat_count = '0;
    logic [127:0] residue;
    logic         residue_valid;

    int           n_cmp = 0;
    int           n_bad = 0;
    int           cyc = 0;
    int           due = 0;
    bit           mon_en = 1'b0;
    bit           done = 1'b0;
    bit           chk_raw = 1'b0;
    logic [15:0]  exp_crc = '0;
    logic [127:0] exp_raw = '0;
    string        tag_q = "R4";
    logic [7:0]   msg_q[$];

    always #5 clk = ~clk;

    crc16_fold_acc u_dut (
        .clk             (clk),
        .rst_n           (rst_n),
        .start_i         (start),
        .init_crc_i      (init_crc),
        .beat_valid_i    (beat_valid),
        .beat_data_i     (beat_data),
        .beat_last_i     (beat_last),
        .beat_count_i    (beat_count),
        .residue_o       (residue),
        .residue_valid_o (residue_valid)
    );

    // One MSB-first step of the generator 0x18BB7.
    function automatic logic [15:0] crc_bit(input logic [15:0] c, input logic b);
        logic fb;
        fb = c[15] ^ b;
        c  = {c[14:0], 1'b0};
        if (fb) c = c ^ 16'h8BB7;
        return c;
    endfunction

    // Final reduction: (x^16 * M) mod G equals the CRC of M's bits from zero.
    function automatic logic [15:0] reduce(input logic [127:0] m);
        logic [15:0] c;
        c = '0;
        for (int i = 127; i >= 0; i--) c = crc_bit(c, m[i]);
        return c;
    endfunction

    task automatic finish_run();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    // Every-clock comparison of the pulse and, when present, the residue.
    always @(posedge clk) begin
        #2;
        if (mon_en) begin
            logic exp_v;
            exp_v = 1'b0;
            if (due > 0) begin
                due   = due - 1;
                exp_v = (due == 0);
            end
            n_cmp++;
            if (residue_valid !== exp_v) begin
                n_bad++;
                $display("FAIL %s valid timing: got %b expected %b", tag_q, residue_valid, exp_v);
            end
            if (exp_v && residue_valid) begin
                n_cmp++;
                if (reduce(residue) !== exp_crc) begin
                    n_bad++;
                    $display("FAIL R3 crc: got %h expected %h", reduce(residue), exp_crc);
                end
                if (chk_raw) begin
                    n_cmp++;
                    if (residue !== exp_raw) begin
                        n_bad++;
                        $display("FAIL R1/R2 residue: got %h expected %h", residue, exp_raw);
                    end
                end
            end
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            n_bad++;
            $display("FAIL watchdog: got %0d cycles expected under 150000", cyc);
            finish_run();
        end
    end

    // Sends one message of len bytes; bytes past the count are filler (R5).
    task automatic send_msg(input logic [15:0] init, input int len);
        int nb, cnt;
        logic [127:0] d;
        logic [15:0] c;
        msg_q.delete();
        for (int i = 0; i < len; i++) msg_q.push_back(8'($urandom));
        c = init;
        for (int i = 0; i < len; i++)
            for (int j = 7; j >= 0; j--) c = crc_bit(c, msg_q[i][j]);
        @(negedge clk);
        start = 1'b1; init_crc = init; beat_valid = 1'b0;
        @(negedge clk);
        start = 1'b0;
        nb = (len + 15) / 16;
        for (int b = 0; b < nb; b++) begin
            cnt = (b == nb - 1) ? len - 16 * b : 16;
            for (int k = 0; k < 16; k++) d[8*k +: 8] = (k < cnt) ? msg_q[16*b + k] : 8'hC3;
            beat_data = d; beat_valid = 1'b1;
            beat_last = (b == nb - 1); beat_count = 5'(cnt);
            if (b == nb - 1) begin
                exp_crc = c;
                due     = (cnt == 16) ? 1 : 2;
                tag_q   = (cnt == 16) ? "R4" : "R5";
                chk_raw = (len == 16);
                for (int k = 0; k < 16; k++) exp_raw[127 - 8*k -: 8] = d[8*k +: 8];
                exp_raw[127:112] = exp_raw[127:112] ^ init;
            end
            @(negedge clk);
        end
        beat_valid = 1'b0; beat_last = 1'b0; beat_count = '0;
        repeat (3) @(negedge clk);
    endtask

    // Offers n beats that must be ignored (idle engine, R6).
    task automatic junk_beats(input int n, input bit last);
        for (int i = 0; i < n; i++) begin
            beat_data = {$urandom, $urandom, $urandom, $urandom};
            beat_valid = 1'b1; beat_last = last; beat_count = 5'd16;
            @(negedge clk);
        end
        beat_valid = 1'b0; beat_last = 1'b0; beat_count = '0;
        repeat (2) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk); #2;
        // R6: reset state of the outputs.
        n_cmp++;
        if (residue !== '0 || residue_valid !== 1'b0) begin
            n_bad++;
            $display("FAIL R6 reset: got %h/%b expected 0/0", residue, residue_valid);
        end
        mon_en = 1'b1;
        @(negedge clk);
        // R6: beats before any start, including last beats, give no pulse.
        junk_beats(3, 1'b1);
        // R1 R2: single-beat messages with several seeds, residue compared directly.
        send_msg(16'h0000, 16);
        send_msg(16'hFFFF, 16);
        send_msg(16'h1D0F, 16);
        // R3 R4 R5: every length from 16 to 300 from a zero seed.
        for (int len = 16; len <= 300; len++) send_msg(16'h0000, len);
        // R2 R3: non-zero seeds on full and short final beats.
        for (int len = 17; len <= 80; len += 7) send_msg(16'(len * 16'h3A5B), len);
        // R6: beats after a finished message are ignored until the next start.
        send_msg(16'hBEEF, 40);
        junk_beats(2, 1'b1);
        send_msg(16'h0000, 33);
        // R6: an abandoned prefix is cleared by the next start.
        @(negedge clk);
        start = 1'b1; init_crc = 16'h5555;
        @(negedge clk);
        start = 1'b0;
        junk_beats(2, 1'b0);
        send_msg(16'h0000, 47);
        send_msg(16'h7777, 31);
        repeat (4) @(negedge clk);
        finish_run();
    end

endmodule